// File: doc/BRIEF.md
# Table-Driven Call and Return Sequencer

This block carries out two control transfers that take several cycles each. The first is a table-indexed call. The sequencer stores the return PC and the status word in a dedicated save pair. It then builds an entry address from a table base register and a 6-bit index, and fetches a 16-bit offset over a simple request/response memory port. The jump target is the table base plus that offset. The second transfer is the matching return, which sends the saved PC and status word back to the core. A second return variant reads from a separate debug save pair instead. The debug pair is loaded through a strobe.

The core presents a decoded-instruction slot together with its current PC, its status word and the table base. The sequencer accepts an instruction only while it is idle, and it holds `busy_o` high until the transfer completes. Completion is a one-cycle pulse on `pc_load_o`, and also on `psw_load_o` for returns. The new values appear on `pc_next_o` and `psw_o` during that pulse.

Top module: `tcs_table_call`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `pc_load_o` and `psw_load_o` are 0. Both save pairs hold zero, so a return issued straight after reset delivers PC 0 and status 0.
- R2: A call starts when `instr_valid_i` is 1 and `instr_i[15:6]` equals 0000001000. The index is taken from `instr_i[5:0]`. Any other encoding starts nothing, and `busy_o` stays 0.
- R3: During a call, `mem_req_o` is raised in the cycle after acceptance with `mem_addr_o` equal to base + (index << 1). Both are held unchanged until a cycle in which `mem_rvalid_i` is 1.
- R4: The call target is base + zero-extended `mem_rdata_i[15:0]`, modulo 2^32, with bit 0 cleared. `pc_load_o` pulses for one cycle, 3 cycles after the acceptance edge plus the number of response wait cycles, so a zero-wait call takes 4 cycles.
- R5: Accepting a call stores `pc_i` + 2 and `psw_i` in the return save pair. A later return delivers exactly these values.
- R6: A return is accepted when `instr_i[15:0]` = 16'h07E0 and `instr_i[31:16]` = 16'h0144. It raises `pc_load_o` and `psw_load_o` together for one cycle, 2 cycles after the acceptance edge (3 cycles in total), with the saved PC and status word.
- R7: When `dbg_save_i` is 1 at a clock edge, `pc_i` and `psw_i` are stored in the debug pair. A debug return (`instr_i[15:0]` = 16'h07E0, `instr_i[31:16]` = 16'h0146) delivers them with the same timing as R6.
- R8: `busy_o` is 1 from the cycle after acceptance through the cycle of the `pc_load_o` pulse, and is 0 after it. Instructions presented while `busy_o` is 1 are ignored.
- R9: `mem_rvalid_i` has no effect when no request is outstanding.
- R10: `psw_load_o` stays 0 when a call completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction slot valid |
| instr_i | input | 32 | Instruction; [15:0] first halfword, [31:16] second |
| pc_i | input | 32 | PC of the presented instruction |
| psw_i | input | 32 | Current status word |
| tbase_i | input | 32 | Table base register value |
| dbg_save_i | input | 1 | Capture pc_i/psw_i into the debug save pair |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table entry address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 16 | Read response halfword |
| busy_o | output | 1 | Sequence in progress |
| pc_load_o | output | 1 | pc_next_o valid, one-cycle pulse |
| pc_next_o | output | 32 | New PC |
| psw_load_o | output | 1 | psw_o valid (returns only) |
| psw_o | output | 32 | Restored status word |

## Verification
The assertions assume the memory returns at most one response per request, and only while `mem_req_o` is high. They also assume the core drops `instr_valid_i` once an instruction has been accepted. The bench drives a response only while a request is outstanding, apart from the one deliberate stray pulse that R9 calls for. It removes the instruction on the negative edge that follows acceptance, and it presents new instructions while busy only to check that they are ignored.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned OFF_W = 16;
  localparam logic [15-IDX_W:0] CALL_OP  = 10'b0000001000;
  localparam logic [15:0]       RET_HW0  = 16'h07E0;
  localparam logic [15:0]       RET_HW1  = 16'h0144;
  localparam logic [15:0]       DRET_HW1 = 16'h0146;

  typedef enum logic [1:0] {OP_NONE, OP_CALL, OP_RET, OP_DRET} tcs_op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CREQ, ST_CADD, ST_CJMP, ST_RRD, ST_RJMP
  } tcs_state_e;
endpackage

// File: rtl/tcs_decode.sv
module tcs_decode
  import tcs_pkg::*;
(
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  output tcs_op_e          op_o,
  output logic [IDX_W-1:0] idx_o
);
  logic is_call, is_ret, is_dret;

  always_comb begin
    is_call = instr_i[15:IDX_W] == CALL_OP;
    is_ret  = (instr_i[15:0] == RET_HW0) && (instr_i[31:16] == RET_HW1);
    is_dret = (instr_i[15:0] == RET_HW0) && (instr_i[31:16] == DRET_HW1);
    op_o = OP_NONE;
    if (valid_i) begin
      if (is_call)      op_o = OP_CALL;
      else if (is_ret)  op_o = OP_RET;
      else if (is_dret) op_o = OP_DRET;
    end
    idx_o = instr_i[IDX_W-1:0];
  end
endmodule

// File: rtl/tcs_save_regs.sv
module tcs_save_regs #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned BANKS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BANKS-1:0] we_i,
  input  logic [XLEN-1:0] pc_wd_i  [BANKS],
  input  logic [XLEN-1:0] psw_wd_i [BANKS],
  input  logic [$clog2(BANKS)-1:0] rsel_i,
  output logic [XLEN-1:0] pc_rd_o,
  output logic [XLEN-1:0] psw_rd_o
);
  logic [XLEN-1:0] pc_q  [BANKS];
  logic [XLEN-1:0] psw_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q[g]  <= '0;
        psw_q[g] <= '0;
      end else if (we_i[g]) begin
        pc_q[g]  <= pc_wd_i[g];
        psw_q[g] <= psw_wd_i[g];
      end
    end
  end

  assign pc_rd_o  = pc_q[rsel_i];
  assign psw_rd_o = psw_q[rsel_i];
endmodule

// File: rtl/tcs_fsm.sv
module tcs_fsm
  import tcs_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tcs_op_e          op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  tbase_i,
  input  logic             mem_rvalid_i,
  input  logic [OFF_W-1:0] mem_rdata_i,
  input  logic [XLEN-1:0]  rd_pc_i,
  input  logic [XLEN-1:0]  rd_psw_i,
  output logic             call_acc_o,
  output logic             sel_dbg_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic             pc_load_o,
  output logic [XLEN-1:0]  pc_next_o,
  output logic             psw_load_o,
  output logic [XLEN-1:0]  psw_o
);
  localparam int unsigned IPAD = XLEN - IDX_W - 1;
  localparam int unsigned OPAD = XLEN - OFF_W;

  tcs_state_e       state_q, state_d;
  logic [XLEN-1:0]  addr_q, base_q, tgt_q, rpc_q, rpsw_q;
  logic [OFF_W-1:0] off_q;
  logic             sel_q;
  logic             idle, ret_acc;
  logic [XLEN-1:0]  sum;

  assign idle       = state_q == ST_IDLE;
  assign call_acc_o = idle && (op_i == OP_CALL);
  assign ret_acc    = idle && ((op_i == OP_RET) || (op_i == OP_DRET));
  assign sum        = base_q + {{OPAD{1'b0}}, off_q};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (call_acc_o) state_d = ST_CREQ;
               else if (ret_acc) state_d = ST_RRD;
      ST_CREQ: if (mem_rvalid_i) state_d = ST_CADD;
      ST_CADD: state_d = ST_CJMP;
      ST_CJMP: state_d = ST_IDLE;
      ST_RRD:  state_d = ST_RJMP;
      ST_RJMP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      tgt_q   <= '0;
      rpc_q   <= '0;
      rpsw_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (call_acc_o) begin
        base_q <= tbase_i;
        addr_q <= tbase_i + {{IPAD{1'b0}}, idx_i, 1'b0};
      end
      if (ret_acc) sel_q <= (op_i == OP_DRET);
      if (state_q == ST_CREQ && mem_rvalid_i) off_q <= mem_rdata_i;
      if (state_q == ST_CADD) tgt_q <= {sum[XLEN-1:1], 1'b0};
      if (state_q == ST_RRD) begin
        rpc_q  <= rd_pc_i;
        rpsw_q <= rd_psw_i;
      end
    end
  end

  assign sel_dbg_o  = sel_q;
  assign busy_o     = !idle;
  assign mem_req_o  = state_q == ST_CREQ;
  assign mem_addr_o = addr_q;
  assign pc_load_o  = (state_q == ST_CJMP) || (state_q == ST_RJMP);
  assign psw_load_o = state_q == ST_RJMP;
  assign pc_next_o  = (state_q == ST_RJMP) ? rpc_q : tgt_q;
  assign psw_o      = rpsw_q;

  AST_CALL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_acc_o |=> mem_req_o && mem_addr_o == $past(tbase_i) + {{IPAD{1'b0}}, $past(idx_i), 1'b0}); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_IDLE_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && mem_rvalid_i && op_i == OP_NONE |=> !busy_o); // R9
  AST_RET_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_acc |=> !pc_load_o ##1 pc_load_o && psw_load_o); // R6
endmodule

// File: rtl/tcs_table_call.sv
module tcs_table_call
  import tcs_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] psw_i,
  input  logic [XLEN-1:0] tbase_i,
  input  logic            dbg_save_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [15:0]     mem_rdata_i,
  output logic            busy_o,
  output logic            pc_load_o,
  output logic [XLEN-1:0] pc_next_o,
  output logic            psw_load_o,
  output logic [XLEN-1:0] psw_o
);
  localparam int unsigned BANKS = 2;

  tcs_op_e          op;
  logic [IDX_W-1:0] idx;
  logic             call_acc, sel_dbg;
  logic [XLEN-1:0]  rd_pc, rd_psw;
  logic [XLEN-1:0]  pc_wd  [BANKS];
  logic [XLEN-1:0]  psw_wd [BANKS];
  logic [BANKS-1:0] we;

  tcs_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .op_o    (op),
    .idx_o   (idx)
  );

  // bank 0: call/return pair, bank 1: debug pair
  assign we        = {dbg_save_i, call_acc};
  assign pc_wd[0]  = pc_i + XLEN'(2);
  assign psw_wd[0] = psw_i;
  assign pc_wd[1]  = pc_i;
  assign psw_wd[1] = psw_i;

  tcs_save_regs #(.XLEN(XLEN), .BANKS(BANKS)) u_save (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .pc_wd_i  (pc_wd),
    .psw_wd_i (psw_wd),
    .rsel_i   (sel_dbg),
    .pc_rd_o  (rd_pc),
    .psw_rd_o (rd_psw)
  );

  tcs_fsm #(.XLEN(XLEN)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .idx_i        (idx),
    .tbase_i      (tbase_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rd_pc_i      (rd_pc),
    .rd_psw_i     (rd_psw),
    .call_acc_o   (call_acc),
    .sel_dbg_o    (sel_dbg),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .pc_load_o    (pc_load_o),
    .pc_next_o    (pc_next_o),
    .psw_load_o   (psw_load_o),
    .psw_o        (psw_o)
  );

  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o && !busy_o); // R8
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> busy_o); // R8
  AST_PSW_WITH_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_load_o |-> pc_load_o); // R6
  AST_TGT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o && !psw_load_o |-> !pc_next_o[0]); // R4
  AST_RESP_TO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> !pc_load_o ##1 pc_load_o && !psw_load_o); // R4 R10
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !pc_load_o); // R1
endmodule

// File: tb/tb_tcs_table_call.sv
module tb_tcs_table_call;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] base;
    logic [31:0] pc;
    logic [31:0] psw;
    logic [15:0] half;
    logic [2:0]  wt;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  32'h0000_1000, 32'h0000_0200, 32'h0000_0001, 16'h0040, 3'd0},
    '{6'd1,  32'h0000_2000, 32'h0000_0A10, 32'h0000_0020, 16'h0101, 3'd2},
    '{6'd63, 32'h1234_0000, 32'h8000_0FFE, 32'hFFFF_0000, 16'hFFFE, 3'd1},
    '{6'd17, 32'hFFFF_FFF0, 32'h0000_3332, 32'h0000_00A5, 16'h0021, 3'd0},
    '{6'd42, 32'h0000_0100, 32'hFFFF_FFFE, 32'h5A5A_5A5A, 16'h0000, 3'd4}
  };

  localparam logic [31:0] RET_W  = 32'h0144_07E0;
  localparam logic [31:0] DRET_W = 32'h0146_07E0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, psw_i = '0, tbase_i = '0;
  logic        dbg_save_i = 1'b0;
  logic        mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        busy_o, pc_load_o, psw_load_o;
  logic [31:0] pc_next_o, psw_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcs_table_call dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .psw_i(psw_i), .tbase_i(tbase_i), .dbg_save_i(dbg_save_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .pc_load_o(pc_load_o),
    .pc_next_o(pc_next_o), .psw_load_o(psw_load_o), .psw_o(psw_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] tgt(logic [31:0] b, logic [15:0] h);
    logic [31:0] s = b + {16'h0, h};
    return {s[31:1], 1'b0};
  endfunction

  // issue a call; optionally present a stray return while busy
  task automatic do_call(vec_t v, bit stray);
    instr_valid_i = 1'b1;
    instr_i = {16'h0, 10'b0000001000, v.idx};
    pc_i = v.pc; psw_i = v.psw; tbase_i = v.base;
    step();
    instr_valid_i = stray;
    instr_i = stray ? RET_W : 32'h0;
    chk("R8", "busy after call accept", {31'b0, busy_o}, 32'd1);
    chk("R3", "req raised", {31'b0, mem_req_o}, 32'd1);
    chk("R3", "table addr", mem_addr_o, v.base + {25'h0, v.idx, 1'b0});
    for (int i = 0; i < v.wt; i++) begin
      step();
      instr_valid_i = 1'b0;
      chk("R3", "req held", {31'b0, mem_req_o}, 32'd1);
      chk("R3", "addr held", mem_addr_o, v.base + {25'h0, v.idx, 1'b0});
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = v.half;
    step();
    instr_valid_i = 1'b0;
    mem_rvalid_i = 1'b0; mem_rdata_i = 16'hDEAD;
    chk("R4", "no load before final cycle", {31'b0, pc_load_o}, 32'd0);
    chk("R3", "req dropped", {31'b0, mem_req_o}, 32'd0);
    step();
    chk("R4", "pc_load in final cycle", {31'b0, pc_load_o}, 32'd1);
    chk("R4", "target pc", pc_next_o, tgt(v.base, v.half));
    chk("R10", "no psw load on call", {31'b0, psw_load_o}, 32'd0);
    chk("R8", "busy in final cycle", {31'b0, busy_o}, 32'd1);
    step();
    chk("R8", "idle after call", {31'b0, busy_o}, 32'd0);
    chk("R8", "single load pulse", {31'b0, pc_load_o}, 32'd0);
  endtask

  task automatic do_ret(logic [31:0] w, logic [31:0] exp_pc, logic [31:0] exp_psw, string req);
    instr_valid_i = 1'b1; instr_i = w;
    pc_i = 32'hABCD_0000; psw_i = 32'h0F0F_0F0F;
    step();
    instr_valid_i = 1'b0; instr_i = '0;
    chk(req, "busy after ret accept", {31'b0, busy_o}, 32'd1);
    chk(req, "no early ret load", {31'b0, pc_load_o}, 32'd0);
    step();
    chk(req, "ret pc_load", {31'b0, pc_load_o}, 32'd1);
    chk(req, "ret psw_load", {31'b0, psw_load_o}, 32'd1);
    chk(req, "ret pc", pc_next_o, exp_pc);
    chk(req, "ret psw", psw_o, exp_psw);
    step();
    chk(req, "idle after ret", {31'b0, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'b0, busy_o}, 32'd0);
    chk("R1", "req in reset", {31'b0, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    step();
    chk("R1", "pc_load after reset", {31'b0, pc_load_o}, 32'd0);
    chk("R1", "psw_load after reset", {31'b0, psw_load_o}, 32'd0);
    do_ret(RET_W, 32'h0, 32'h0, "R1");
    do_ret(DRET_W, 32'h0, 32'h0, "R1");

    // vector table: call then matching return
    for (int k = 0; k < NVEC; k++) begin
      do_call(VECS[k], 1'b0);
      do_ret(RET_W, VECS[k].pc + 32'd2, VECS[k].psw, "R5");
    end

    // R2: near-miss encodings start nothing
    instr_valid_i = 1'b1; instr_i = 32'h0000_0240;
    step();
    chk("R2", "bad call opcode ignored", {31'b0, busy_o}, 32'd0);
    instr_i = 32'h0145_07E0;
    step();
    chk("R2", "bad ret halfword ignored", {31'b0, busy_o}, 32'd0);
    instr_valid_i = 1'b0; instr_i = 32'h0000_0205;
    step();
    chk("R2", "call without valid ignored", {31'b0, busy_o}, 32'd0);

    // R9: stray response while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 16'h7777;
    step();
    mem_rvalid_i = 1'b0;
    chk("R9", "stray rvalid busy", {31'b0, busy_o}, 32'd0);
    chk("R9", "stray rvalid load", {31'b0, pc_load_o}, 32'd0);

    // R8: return presented during call is ignored; saved pair from this call
    do_call(VECS[1], 1'b1);
    chk("R8", "stray ret not started", {31'b0, psw_load_o}, 32'd0);

    // R7: debug pair independent of call pair
    dbg_save_i = 1'b1; pc_i = 32'h0000_4444; psw_i = 32'h0000_0D0D;
    step();
    dbg_save_i = 1'b0;
    do_ret(DRET_W, 32'h0000_4444, 32'h0000_0D0D, "R7");
    do_ret(RET_W, VECS[1].pc + 32'd2, VECS[1].psw, "R6");
    do_call(VECS[3], 1'b0);
    do_ret(DRET_W, 32'h0000_4444, 32'h0000_0D0D, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule